// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge turns a 32 MiB alias window into single-bit access to a 1 MiB target region. Each 32-bit word in the window stands for one bit of the target. A requester on the slave port sends the offset into the window, an access size of 1, 2 or 4 bytes and, for writes, a data word. The bridge issues byte-enabled transfers on its master port toward the target memory.

A read fetches the target unit that holds the selected bit and returns that bit alone. A write is an atomic read-modify-write. The bridge fetches the unit, forces the selected bit to write-data bit 0, and writes the unit back with the same address and byte enables. New requests are held off until the whole sequence has finished. The target base is a parameter, so one instance can serve the SRAM alias and another the peripheral alias.

Top module: `bitband_bridge`

## Requirements
- R1: The master address is `TGT_BASE | (s_req_off >> 5)`, aligned down to the access size. `s_req_size` holds the byte count: 1, 2 or 4.
- R2: Byte enables on the master port cover exactly the fetched unit on a little-endian 32-bit bus. Byte lane n is data bits [8n+7:8n]. A 1-byte unit at address a uses lane a[1:0]. A 2-byte unit uses lanes 1:0 when a[1]=0 and lanes 3:2 when a[1]=1. A 4-byte unit uses all four lanes.
- R3: The bit position inside the unit is `(s_req_off >> 2) & (size*8-1)`. Its byte index is that value divided by 8, and its bit inside the byte is that value mod 8. On the 32-bit bus this always places the selected bit at bit `s_req_off[6:2]`.
- R4: A successful read responds with the selected bit in `s_rsp_rdata[0]` and zero in every other bit.
- R5: A write performs exactly one target read followed by one target write to the same address with the same byte enables. The written unit equals the fetched unit except at the selected bit, which becomes `s_req_wdata[0]`.
- R6: An error on the target read ends the request with `s_rsp_err`=1, and no write-back is issued.
- R7: An error on the write-back is returned as `s_rsp_err`=1.
- R8: A request whose size is not 1, 2 or 4 gets an error response and makes no master-port request.
- R9: `s_req_ready` is low from the cycle after a request is accepted until the cycle after its single one-cycle response pulse. This keeps a read-modify-write from being split.
- R10: After reset, `s_req_ready` is 1, and `m_req_valid` and `s_rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_req_valid | input | 1 | Slave request valid |
| s_req_ready | output | 1 | Bridge can accept a request |
| s_req_write | input | 1 | 1 = write, 0 = read |
| s_req_off | input | ALIAS_W (25) | Offset into the alias window |
| s_req_size | input | 3 | Access size in bytes (1, 2, 4 valid) |
| s_req_wdata | input | 32 | Write data; bit 0 is the new bit value |
| s_rsp_valid | output | 1 | One-cycle response pulse |
| s_rsp_rdata | output | 32 | Read result (selected bit in bit 0) |
| s_rsp_err | output | 1 | Response error flag |
| m_req_valid | output | 1 | Master request valid |
| m_req_ready | input | 1 | Target accepts the request |
| m_req_write | output | 1 | Master request is a write |
| m_req_addr | output | 32 | Target byte address |
| m_req_be | output | 4 | Byte enables |
| m_req_wdata | output | 32 | Write-back data |
| m_rsp_valid | input | 1 | Target response valid |
| m_rsp_rdata | input | 32 | Target read data |
| m_rsp_err | input | 1 | Target error flag |

## Verification
Reads sweep all 32 alias words of a target word at each of the three sizes, over a pattern with mixed ones and zeros. A wrong lane or bit-position mapping therefore returns the neighbouring bit's value, and the observed address and byte enables show which size term is wrong. Writes sweep every bit at every size with alternating values, followed by a read-back. Comparing the whole target word against a shadow model exposes any stray bit that the merge disturbs. Errors injected separately on the fetch and on the write-back show whether the sequence stops or continues. Illegal sizes show whether the bridge ever reaches the master port.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int BUS_W  = 32;
  localparam int BE_W   = BUS_W / 8;
  localparam int IDX_W  = $clog2(BUS_W);
  localparam int LANE_W = $clog2(BE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_WR_WAIT, ST_RESP
  } bb_state_e;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  // mask that keeps bit positions inside a unit of sz bytes
  function automatic logic [IDX_W-1:0] unit_bit_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    return IDX_W'(7);
      3'd2:    return IDX_W'(15);
      default: return IDX_W'(31);
    endcase
  endfunction

  function automatic logic [BE_W-1:0] unit_lanes(input logic [2:0] sz,
                                                 input logic [LANE_W-1:0] lane);
    case (sz)
      3'd1:    return BE_W'(1) << lane;
      3'd2:    return BE_W'(3) << lane;
      default: return {BE_W{1'b1}};
    endcase
  endfunction

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
  import bb_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          ALIAS_W  = 25,
  parameter logic [31:0] TGT_BASE = 32'h2000_0000
) (
  input  logic [ALIAS_W-1:0] off,
  input  logic [2:0]         size,
  output logic [ADDR_W-1:0]  tgt_addr,
  output logic [BE_W-1:0]    be,
  output logic [IDX_W-1:0]   bus_bit
);
  localparam int WORD_SHIFT = IDX_W;          // one alias word per target bit
  localparam int BYTE_OFF_W = ALIAS_W - WORD_SHIFT;

  logic [BYTE_OFF_W-1:0] byte_off;
  logic [ADDR_W-1:0]     raw_addr;
  logic [ADDR_W-1:0]     align_mask;
  logic [IDX_W-1:0]      unit_pos;
  logic [LANE_W-1:0]     lane;

  always_comb begin
    byte_off   = off[ALIAS_W-1:WORD_SHIFT];
    raw_addr   = ADDR_W'(TGT_BASE) | ADDR_W'(byte_off);
    align_mask = ~(ADDR_W'(size) - ADDR_W'(1));
    tgt_addr   = raw_addr & align_mask;
    lane       = tgt_addr[LANE_W-1:0];
    unit_pos   = off[IDX_W+1:2] & unit_bit_mask(size);
    bus_bit    = {lane, 3'b000} + unit_pos;
    be         = unit_lanes(size, lane);
  end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [BUS_W-1:0] fetched,
  input  logic [IDX_W-1:0] bus_bit,
  input  logic             new_val,
  output logic             sel_bit,
  output logic [BUS_W-1:0] merged
);
  always_comb begin
    sel_bit = fetched[bus_bit];
    merged  = fetched;
    merged[bus_bit] = new_val;
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int          ALIAS_W  = 25,
  parameter logic [31:0] TGT_BASE = 32'h2000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_req_valid,
  output logic               s_req_ready,
  input  logic               s_req_write,
  input  logic [ALIAS_W-1:0] s_req_off,
  input  logic [2:0]         s_req_size,
  input  logic [31:0]        s_req_wdata,
  output logic               s_rsp_valid,
  output logic [31:0]        s_rsp_rdata,
  output logic               s_rsp_err,
  output logic               m_req_valid,
  input  logic               m_req_ready,
  output logic               m_req_write,
  output logic [31:0]        m_req_addr,
  output logic [3:0]         m_req_be,
  output logic [31:0]        m_req_wdata,
  input  logic               m_rsp_valid,
  input  logic [31:0]        m_rsp_rdata,
  input  logic               m_rsp_err
);

  bb_state_e          state;
  logic [ALIAS_W-1:0] q_off;
  logic [2:0]         q_size;
  logic               q_write;
  logic               q_newbit;
  logic [BUS_W-1:0]   wb_word;
  logic               rsp_bit;
  logic               rsp_err_q;

  logic [31:0]      map_addr;
  logic [BE_W-1:0]  map_be;
  logic [IDX_W-1:0] map_bit;
  logic             pick_bit;
  logic [BUS_W-1:0] pick_merged;

  // named events used by the checker
  logic accept, bad_size_evt, rd_done, rd_fail, busy;

  logic unused_bits;
  assign unused_bits = ^{s_req_off[1:0], s_req_wdata[31:1]};

  bb_addr_map #(.ADDR_W(32), .ALIAS_W(ALIAS_W), .TGT_BASE(TGT_BASE)) u_map (
    .off(q_off), .size(q_size),
    .tgt_addr(map_addr), .be(map_be), .bus_bit(map_bit)
  );

  bb_bit_merge u_merge (
    .fetched(m_rsp_rdata), .bus_bit(map_bit), .new_val(q_newbit),
    .sel_bit(pick_bit), .merged(pick_merged)
  );

  assign s_req_ready  = (state == ST_IDLE);
  assign accept       = s_req_valid && s_req_ready;
  assign bad_size_evt = accept && !size_legal(s_req_size);
  assign rd_done      = (state == ST_RD_WAIT) && m_rsp_valid;
  assign rd_fail      = rd_done && m_rsp_err;
  assign busy         = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      q_off     <= '0;
      q_size    <= 3'd4;
      q_write   <= 1'b0;
      q_newbit  <= 1'b0;
      wb_word   <= '0;
      rsp_bit   <= 1'b0;
      rsp_err_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          q_off     <= s_req_off;
          q_size    <= s_req_size;
          q_write   <= s_req_write;
          q_newbit  <= s_req_wdata[0];
          rsp_bit   <= 1'b0;
          rsp_err_q <= !size_legal(s_req_size);
          state     <= size_legal(s_req_size) ? ST_RD_REQ : ST_RESP;
        end
        ST_RD_REQ:  if (m_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (m_rsp_valid) begin
          if (m_rsp_err) begin
            rsp_err_q <= 1'b1;
            state     <= ST_RESP;
          end else if (q_write) begin
            wb_word <= pick_merged;
            state   <= ST_WR_REQ;
          end else begin
            rsp_bit <= pick_bit;
            state   <= ST_RESP;
          end
        end
        ST_WR_REQ:  if (m_req_ready) state <= ST_WR_WAIT;
        ST_WR_WAIT: if (m_rsp_valid) begin
          rsp_err_q <= m_rsp_err;
          state     <= ST_RESP;
        end
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign m_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign m_req_write = (state == ST_WR_REQ);
  assign m_req_addr  = map_addr;
  assign m_req_be    = map_be;
  assign m_req_wdata = wb_word;
  assign s_rsp_valid = (state == ST_RESP);
  assign s_rsp_err   = rsp_err_q;
  assign s_rsp_rdata = {31'd0, rsp_bit};

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_req_ready,
  input logic        s_rsp_valid,
  input logic        s_rsp_err,
  input logic [31:0] s_rsp_rdata,
  input logic        m_req_valid,
  input logic        m_req_ready,
  input logic        m_req_write,
  input logic [31:0] m_req_addr,
  input logic [3:0]  m_req_be,
  input logic        busy,
  input logic        rd_fail,
  input logic        bad_size_evt
);

  assert_ready_low_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !s_req_ready);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_rsp_valid |=> !s_rsp_valid);

  assert_no_wb_after_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fail |=> (!m_req_valid && s_rsp_valid && s_rsp_err));

  assert_bad_size_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_size_evt |=> (!m_req_valid && s_rsp_valid && s_rsp_err));

  assert_read_bit_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s_rsp_valid |-> (s_rsp_rdata[31:1] == 31'd0));

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && !m_req_ready) |=> ($stable(m_req_addr) && $stable(m_req_be)));

  assert_be_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid |-> ($countones(m_req_be) == 1 || m_req_be == 4'b0011 ||
                     m_req_be == 4'b1100 || m_req_be == 4'b1111));

  assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req_valid && !m_req_write) |=> !(m_req_valid && m_req_write));

endmodule

bind bitband_bridge bitband_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_req_ready(s_req_ready), .s_rsp_valid(s_rsp_valid),
  .s_rsp_err(s_rsp_err), .s_rsp_rdata(s_rsp_rdata), .m_req_valid(m_req_valid),
  .m_req_ready(m_req_ready), .m_req_write(m_req_write), .m_req_addr(m_req_addr),
  .m_req_be(m_req_be), .busy(busy), .rd_fail(rd_fail), .bad_size_evt(bad_size_evt)
);

// File: tb/bitband_bridge_tb.sv
`timescale 1ns/1ps
module bitband_bridge_tb;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_req_valid = 1'b0, s_req_write = 1'b0;
  logic [24:0] s_req_off = '0;
  logic [2:0]  s_req_size = 3'd4;
  logic [31:0] s_req_wdata = '0;
  logic        s_req_ready, s_rsp_valid, s_rsp_err;
  logic [31:0] s_rsp_rdata;
  logic        m_req_valid, m_req_write;
  logic        m_req_ready = 1'b1;
  logic [31:0] m_req_addr, m_req_wdata;
  logic [3:0]  m_req_be;
  logic        m_rsp_valid = 1'b0, m_rsp_err = 1'b0;
  logic [31:0] m_rsp_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [0:63];
  logic [31:0] shadow [0:63];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_addr;
  logic [3:0]  last_be;
  bit inj_rd_err = 0, inj_wr_err = 0;

  always #4 clk = ~clk;

  bitband_bridge #(.ALIAS_W(25), .TGT_BASE(BASE)) u_dut (.*);

  // target memory model: responds one cycle after a request is accepted
  initial begin
    bit pend = 0; logic [31:0] pdata; bit perr;
    forever begin
      @(negedge clk);
      if (pend) begin
        m_rsp_valid = 1; m_rsp_rdata = pdata; m_rsp_err = perr; pend = 0;
      end else begin
        m_rsp_valid = 0; m_rsp_err = 0;
      end
      if (m_req_valid) begin
        last_addr = m_req_addr; last_be = m_req_be; pend = 1; pdata = '0;
        if (m_req_write) begin
          wr_cnt++; perr = inj_wr_err;
          if (!inj_wr_err)
            for (int l = 0; l < 4; l++)
              if (m_req_be[l]) mem[m_req_addr[7:2]][l*8 +: 8] = m_req_wdata[l*8 +: 8];
        end else begin
          rd_cnt++; perr = inj_rd_err; pdata = mem[m_req_addr[7:2]];
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL R9 watchdog expired actual=hang expected=response");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [24:0] off, input logic [2:0] sz);
    logic [31:0] a = BASE + {12'd0, off[24:5]};
    return a - (a % sz);
  endfunction

  function automatic logic [3:0] exp_be(input logic [24:0] off, input logic [2:0] sz);
    if (sz == 3'd4) return 4'hF;
    if (sz == 3'd2) return off[6] ? 4'b1100 : 4'b0011;
    return 4'b0001 << off[6:5];
  endfunction

  task automatic xact(input bit wr, input logic [24:0] off, input logic [2:0] sz,
                      input bit val, output logic [31:0] rd, output bit er);
    @(negedge clk);
    s_req_valid = 1; s_req_write = wr; s_req_off = off; s_req_size = sz;
    s_req_wdata = {31'h5555_AAAA, val};
    @(negedge clk);
    s_req_valid = 0;
    chk(!s_req_ready, "R9 busy", {31'd0, s_req_ready}, 32'd0);
    for (int n = 0; n < 50 && !s_rsp_valid; n++) @(negedge clk);
    chk(s_rsp_valid, "R9 response", {31'd0, s_rsp_valid}, 32'd1);
    rd = s_rsp_rdata; er = s_rsp_err;
    @(negedge clk);
    chk(!s_rsp_valid && s_req_ready, "R9 single pulse", {30'd0, s_rsp_valid, s_req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk(s_req_ready && !m_req_valid && !s_rsp_valid, "R10 reset",
        {29'd0, s_req_ready, m_req_valid, s_rsp_valid}, 32'd4);
  endtask

  task automatic t_read_sweep;
    logic [31:0] rd; bit er;
    for (int s = 0; s < 3; s++) begin
      logic [2:0] sz = 3'(1 << s);
      int w = 4 + s;
      for (int b = 0; b < 32; b++) begin
        logic [24:0] off = 25'((w * 4) * 32 + b * 4);
        xact(0, off, sz, 0, rd, er);
        chk(!er && rd == {31'd0, shadow[w][off[6:2]]}, "R3 R4 read bit", rd, {31'd0, shadow[w][off[6:2]]});
        chk(last_addr == exp_addr(off, sz), "R1 address", last_addr, exp_addr(off, sz));
        chk(last_be == exp_be(off, sz), "R2 byte enables", {28'd0, last_be}, {28'd0, exp_be(off, sz)});
      end
    end
  endtask

  task automatic t_write_sweep;
    logic [31:0] rd; bit er; int r0, w0;
    for (int s = 0; s < 3; s++) begin
      logic [2:0] sz = 3'(1 << s);
      int w = 10 + s;
      for (int b = 0; b < 32; b++) begin
        logic [24:0] off = 25'((w * 4) * 32 + b * 4);
        bit v = ~shadow[w][b];
        r0 = rd_cnt; w0 = wr_cnt;
        xact(1, off, sz, v, rd, er);
        shadow[w][b] = v;
        chk(!er && rd_cnt == r0 + 1 && wr_cnt == w0 + 1, "R5 one read one write",
            32'(wr_cnt - w0), 32'd1);
        chk(mem[w] == shadow[w], "R5 merged word", mem[w], shadow[w]);
        xact(0, off, sz, 0, rd, er);
        chk(rd == {31'd0, v}, "R5 read after write", rd, {31'd0, v});
      end
    end
  endtask

  task automatic t_errors;
    logic [31:0] rd; bit er; int w0; logic [31:0] keep;
    keep = mem[20]; w0 = wr_cnt; inj_rd_err = 1;
    xact(1, 25'(20 * 4 * 32 + 9 * 4), 3'd4, ~keep[9], rd, er);
    inj_rd_err = 0;
    chk(er, "R6 read error flagged", {31'd0, er}, 32'd1);
    chk(wr_cnt == w0 && mem[20] == keep, "R6 no write-back", 32'(wr_cnt - w0), 32'd0);
    inj_wr_err = 1;
    xact(1, 25'(20 * 4 * 32 + 3 * 4), 3'd1, ~keep[3], rd, er);
    inj_wr_err = 0;
    chk(er && wr_cnt == w0 + 1, "R7 write-back error", {31'd0, er}, 32'd1);
  endtask

  task automatic t_bad_size;
    logic [31:0] rd; bit er; int r0;
    logic [2:0] bad [5] = '{3'd0, 3'd3, 3'd5, 3'd6, 3'd7};
    foreach (bad[i]) begin
      r0 = rd_cnt;
      xact(0, 25'h40, bad[i], 0, rd, er);
      chk(er && rd_cnt == r0 && wr_cnt >= 0, "R8 illegal size", {31'd0, er}, 32'd1);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'hA5C3_0F69 ^ (32'(i) * 32'h0101_0107);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_read_sweep();
    t_write_sweep();
    t_errors();
    t_bad_size();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule